// File: doc/BRIEF.md
# IDE Channel I/O Address Decoder

This block turns the configuration state of a two-channel IDE host adapter into the I/O port windows that the adapter answers on, and decodes each incoming 16-bit I/O address against them. Each channel has a command block of eight ports and a single control port. Each channel sits either at its fixed compatibility ports or, in native mode, at addresses taken from its base address registers. A 16-port bus-master register block holds the primary channel's registers in its lower half and the secondary channel's in its upper half.

The decode path is purely combinational. A configuration change therefore shows up in the very next I/O cycle. The address side is a valid-qualified stream with no ready signal: the decoder answers every address in the cycle it is presented, so it never applies back-pressure. The block also reports, per channel, whether the channel's interrupt goes to the compatibility line or to the PCI interrupt pin. Register behaviour behind the decode belongs to other blocks.

Top module: `ide_io_decoder`

## Requirements
- R1: A channel uses native addressing only when its native-request input (`cfg_pri_native_req` or `cfg_sec_native_req`) is 1 and `cfg_native_allow` is 1. In every other case it uses compatibility addressing.
- R2: In native mode the command base is the command BAR with bits [2:0] cleared, and the window covers base+0 to base+7. The control port is the control BAR with bits [1:0] cleared, plus 2, and only that one port decodes.
- R3: In compatibility mode the primary channel uses command ports 0x1F0 to 0x1F7 and control port 0x3F6. The secondary channel uses 0x170 to 0x177 and 0x376.
- R4: `pri_irq_pin` and `sec_irq_pin` are 1 (PCI interrupt pin) exactly when the channel's native-request input is 1, whatever the value of `cfg_native_allow`.
- R5: The primary channel decodes only when `cfg_io_en` is 1. The secondary channel decodes only when both `cfg_io_en` and `cfg_sec_enable` are 1.
- R6: The bus-master base is the bus-master BAR with bits [3:0] cleared. Addresses base+0 to base+7 hit the primary channel and base+8 to base+15 hit the secondary channel. The block decodes only when `cfg_io_en` is 1 and does not depend on `cfg_sec_enable`.
- R7: With parameter `SINGLE_CHANNEL`=1, the secondary command, control and bus-master windows never decode, and `sec_active` is 0.
- R8: When windows overlap, the match is chosen in this order: primary command, primary control, secondary command, secondary control, bus-master.
- R9: While `io_valid` is 0, `dec_hit` is 0 and `dec_kind` is 0.
- R10: Result encoding. `dec_kind` is 0 for none, 1 for command, 2 for control and 3 for bus-master. `dec_chan` is 0 for primary and 1 for secondary. `dec_offset` is the address minus the window base for a command hit, 0 for a control hit, and address bits [2:0] for a bus-master hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_pri_native_req | input | 1 | Programming-interface request for native mode, primary |
| cfg_sec_native_req | input | 1 | Programming-interface request for native mode, secondary |
| cfg_native_allow | input | 1 | Global permission for native (BAR-based) addressing |
| cfg_io_en | input | 1 | I/O space enable from the command register |
| cfg_sec_enable | input | 1 | Secondary channel enable |
| cfg_pri_cmd_bar | input | 16 | Primary command-block BAR |
| cfg_pri_ctl_bar | input | 16 | Primary control-block BAR |
| cfg_sec_cmd_bar | input | 16 | Secondary command-block BAR |
| cfg_sec_ctl_bar | input | 16 | Secondary control-block BAR |
| cfg_bm_bar | input | 16 | Bus-master block BAR |
| io_valid | input | 1 | An I/O address is presented |
| io_addr | input | 16 | I/O address to decode |
| dec_hit | output | 1 | Address falls in an active window |
| dec_chan | output | 1 | Channel of the hit |
| dec_kind | output | 2 | Window type of the hit |
| dec_offset | output | 3 | Register offset inside the window |
| pri_cmd_base | output | 16 | Effective primary command base |
| pri_ctl_port | output | 16 | Effective primary control port |
| sec_cmd_base | output | 16 | Effective secondary command base |
| sec_ctl_port | output | 16 | Effective secondary control port |
| bm_base | output | 16 | Effective bus-master block base |
| pri_irq_pin | output | 1 | Primary interrupt routed to PCI pin |
| sec_irq_pin | output | 1 | Secondary interrupt routed to PCI pin |
| pri_active | output | 1 | Primary channel windows enabled |
| sec_active | output | 1 | Secondary channel windows enabled |

## Verification
The main decode is tried with addresses inside, at the edges of and just beside each window, under fully native, fully compatibility and mixed per-channel settings. A mixed setting shows that native selection is per channel and not global. Runs with each enable cleared in turn separate the primary gating from the secondary gating, and show that the bus-master upper half ignores the secondary enable. Overlapping BAR settings expose the priority order, and a single-channel instance shows that every secondary window is suppressed. The interrupt-routing outputs are checked with native permission both granted and withheld, which separates routing from addressing.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int CMD_SPAN = 8;
  localparam int BM_SPAN  = 16;
  localparam int OFF_W    = $clog2(CMD_SPAN);

  localparam logic [15:0] PRI_LEG_CMD = 16'h01F0;
  localparam logic [15:0] PRI_LEG_CTL = 16'h03F6;
  localparam logic [15:0] SEC_LEG_CMD = 16'h0170;
  localparam logic [15:0] SEC_LEG_CTL = 16'h0376;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_CTL  = 2'd2,
    KIND_BM   = 2'd3
  } win_kind_e;
endpackage

// File: rtl/ide_chan_window.sv
module ide_chan_window
  import ide_dec_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] LEG_CMD = 16'h01F0,
  parameter logic [15:0] LEG_CTL = 16'h03F6
) (
  input  logic              native_i,
  input  logic              irq_sel_i,
  input  logic              enable_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] cmd_bar_i,
  input  logic [ADDR_W-1:0] ctl_bar_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cmd_base_o,
  output logic [ADDR_W-1:0] ctl_port_o,
  output logic              irq_pin_o,
  output logic              cmd_hit_o,
  output logic              ctl_hit_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [ADDR_W-1:0] CMD_MASK = ~ADDR_W'(CMD_SPAN - 1);
  localparam logic [ADDR_W-1:0] CTL_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] CTL_ADJ  = ADDR_W'(2);

  always_comb begin
    if (native_i) begin
      cmd_base_o = cmd_bar_i & CMD_MASK;
      ctl_port_o = (ctl_bar_i & CTL_MASK) + CTL_ADJ;
    end else begin
      cmd_base_o = ADDR_W'(LEG_CMD);
      ctl_port_o = ADDR_W'(LEG_CTL);
    end
  end

  assign irq_pin_o = irq_sel_i;
  assign cmd_hit_o = valid_i & enable_i & (((addr_i ^ cmd_base_o) & CMD_MASK) == '0);
  assign ctl_hit_o = valid_i & enable_i & (addr_i == ctl_port_o);
  assign off_o     = addr_i[OFF_W-1:0];

  logic [ADDR_W-1:0] cmd_dist;
  assign cmd_dist = addr_i - cmd_base_o;

  always_comb begin
    if (cmd_hit_o)
      assert_cmd_span_R2: assert (cmd_dist < ADDR_W'(CMD_SPAN))
        else $error("command hit outside its span");
    if (!native_i)
      assert_legacy_base_R3: assert (cmd_base_o == ADDR_W'(LEG_CMD) && ctl_port_o == ADDR_W'(LEG_CTL))
        else $error("compatibility ports wrong");
    if (native_i)
      assert_native_irq_R4: assert (irq_pin_o)
        else $error("native channel not on interrupt pin");
  end
endmodule

// File: rtl/ide_bm_window.sv
module ide_bm_window
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              enable_i,
  input  logic              valid_i,
  input  logic [1:0]        chan_en_i,
  input  logic [ADDR_W-1:0] bar_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              hit_o,
  output logic              chan_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int                HALF_BIT = $clog2(BM_SPAN) - 1;
  localparam logic [ADDR_W-1:0] BM_MASK  = ~ADDR_W'(BM_SPAN - 1);

  logic in_block;

  assign base_o   = bar_i & BM_MASK;
  assign in_block = ((addr_i ^ base_o) & BM_MASK) == '0;
  assign chan_o   = addr_i[HALF_BIT];
  assign hit_o    = valid_i & enable_i & in_block & chan_en_i[chan_o];
  assign off_o    = addr_i[OFF_W-1:0];

  always_comb begin
    if (hit_o)
      assert_bm_range_R6: assert ((addr_i - base_o) < ADDR_W'(BM_SPAN))
        else $error("bus-master hit outside block");
  end
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter bit SINGLE_CHANNEL = 1'b0
) (
  input  logic              cfg_pri_native_req,
  input  logic              cfg_sec_native_req,
  input  logic              cfg_native_allow,
  input  logic              cfg_io_en,
  input  logic              cfg_sec_enable,
  input  logic [ADDR_W-1:0] cfg_pri_cmd_bar,
  input  logic [ADDR_W-1:0] cfg_pri_ctl_bar,
  input  logic [ADDR_W-1:0] cfg_sec_cmd_bar,
  input  logic [ADDR_W-1:0] cfg_sec_ctl_bar,
  input  logic [ADDR_W-1:0] cfg_bm_bar,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              dec_hit,
  output logic              dec_chan,
  output logic [1:0]        dec_kind,
  output logic [OFF_W-1:0]  dec_offset,
  output logic [ADDR_W-1:0] pri_cmd_base,
  output logic [ADDR_W-1:0] pri_ctl_port,
  output logic [ADDR_W-1:0] sec_cmd_base,
  output logic [ADDR_W-1:0] sec_ctl_port,
  output logic [ADDR_W-1:0] bm_base,
  output logic              pri_irq_pin,
  output logic              sec_irq_pin,
  output logic              pri_active,
  output logic              sec_active
);
  localparam int NCH = 2;

  logic [NCH-1:0]             ch_req, ch_en, cmd_hit, ctl_hit, irq_pin;
  logic [NCH-1:0][ADDR_W-1:0] cmd_bar, ctl_bar, cmd_base, ctl_port;
  logic [NCH-1:0][OFF_W-1:0]  ch_off;
  logic                       bm_hit, bm_chan;
  logic [OFF_W-1:0]           bm_off;
  logic [1:0]                 bm_chan_en;
  win_kind_e                  kind;

  assign ch_req  = {cfg_sec_native_req, cfg_pri_native_req};
  assign cmd_bar = {cfg_sec_cmd_bar, cfg_pri_cmd_bar};
  assign ctl_bar = {cfg_sec_ctl_bar, cfg_pri_ctl_bar};
  assign ch_en[0] = cfg_io_en;

  generate
    if (SINGLE_CHANNEL) begin : g_single
      assign ch_en[1]   = 1'b0;
      assign bm_chan_en = {1'b0, 1'b1};
    end else begin : g_dual
      assign ch_en[1]   = cfg_io_en & cfg_sec_enable;
      assign bm_chan_en = 2'b11;
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      localparam logic [15:0] LCMD = (gi == 0) ? PRI_LEG_CMD : SEC_LEG_CMD;
      localparam logic [15:0] LCTL = (gi == 0) ? PRI_LEG_CTL : SEC_LEG_CTL;
      ide_chan_window #(
        .ADDR_W (ADDR_W),
        .LEG_CMD(LCMD),
        .LEG_CTL(LCTL)
      ) i_win (
        .native_i  (ch_req[gi] & cfg_native_allow),
        .irq_sel_i (ch_req[gi]),
        .enable_i  (ch_en[gi]),
        .valid_i   (io_valid),
        .cmd_bar_i (cmd_bar[gi]),
        .ctl_bar_i (ctl_bar[gi]),
        .addr_i    (io_addr),
        .cmd_base_o(cmd_base[gi]),
        .ctl_port_o(ctl_port[gi]),
        .irq_pin_o (irq_pin[gi]),
        .cmd_hit_o (cmd_hit[gi]),
        .ctl_hit_o (ctl_hit[gi]),
        .off_o     (ch_off[gi])
      );
    end
  endgenerate

  ide_bm_window #(.ADDR_W(ADDR_W)) i_bm (
    .enable_i (cfg_io_en),
    .valid_i  (io_valid),
    .chan_en_i(bm_chan_en),
    .bar_i    (cfg_bm_bar),
    .addr_i   (io_addr),
    .base_o   (bm_base),
    .hit_o    (bm_hit),
    .chan_o   (bm_chan),
    .off_o    (bm_off)
  );

  // Fixed priority across overlapping windows.
  always_comb begin
    kind       = KIND_NONE;
    dec_chan   = 1'b0;
    dec_offset = '0;
    if (cmd_hit[0]) begin
      kind       = KIND_CMD;
      dec_offset = ch_off[0];
    end else if (ctl_hit[0]) begin
      kind = KIND_CTL;
    end else if (cmd_hit[1]) begin
      kind       = KIND_CMD;
      dec_chan   = 1'b1;
      dec_offset = ch_off[1];
    end else if (ctl_hit[1]) begin
      kind     = KIND_CTL;
      dec_chan = 1'b1;
    end else if (bm_hit) begin
      kind       = KIND_BM;
      dec_chan   = bm_chan;
      dec_offset = bm_off;
    end
  end

  assign dec_kind     = kind;
  assign dec_hit      = (kind != KIND_NONE);
  assign pri_cmd_base = cmd_base[0];
  assign pri_ctl_port = ctl_port[0];
  assign sec_cmd_base = cmd_base[1];
  assign sec_ctl_port = ctl_port[1];
  assign pri_irq_pin  = irq_pin[0];
  assign sec_irq_pin  = irq_pin[1];
  assign pri_active   = ch_en[0];
  assign sec_active   = ch_en[1];

  always_comb begin
    if (!cfg_io_en)
      assert_io_gate_R5: assert (!dec_hit)
        else $error("decode while I/O disabled");
    if (dec_hit && dec_chan && dec_kind != KIND_BM)
      assert_sec_gate_R5: assert (cfg_sec_enable && cfg_io_en)
        else $error("secondary decoded while disabled");
    if (SINGLE_CHANNEL)
      assert_single_R7: assert (!(dec_hit && dec_chan) && !sec_active)
        else $error("secondary active in single-channel build");
    if (!io_valid)
      assert_idle_R9: assert (!dec_hit && dec_kind == 2'd0)
        else $error("hit without valid address");
    if (cmd_hit[0])
      assert_prio_R8: assert (dec_kind == 2'd1 && !dec_chan)
        else $error("primary command lost priority");
  end
endmodule

// File: tb/test_ide_io_decoder.sv
module test_ide_io_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  nat;
    logic        allow;
    logic        io;
    logic        sec;
    logic [15:0] addr;
    logic        hit;
    logic        chan;
    logic [1:0]  kind;
    logic [2:0]  off;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hD003, 1'b1, 1'b0, 2'd1, 3'd3},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hD406, 1'b1, 1'b0, 2'd2, 3'd0},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hD405, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hD80F, 1'b1, 1'b1, 2'd1, 3'd7},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hDC06, 1'b1, 1'b1, 2'd2, 3'd0},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'h01F0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h01F7, 1'b1, 1'b0, 2'd1, 3'd7},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h03F6, 1'b1, 1'b0, 2'd2, 3'd0},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h0176, 1'b1, 1'b1, 2'd1, 3'd6},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h0376, 1'b1, 1'b1, 2'd2, 3'd0},
    '{2'b01, 1'b1, 1'b1, 1'b1, 16'hD000, 1'b1, 1'b0, 2'd1, 3'd0},
    '{2'b01, 1'b1, 1'b1, 1'b1, 16'h0170, 1'b1, 1'b1, 2'd1, 3'd0},
    '{2'b10, 1'b1, 1'b1, 1'b1, 16'h01F2, 1'b1, 1'b0, 2'd1, 3'd2},
    '{2'b00, 1'b1, 1'b1, 1'b0, 16'h0170, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b00, 1'b1, 1'b1, 1'b0, 16'h01F1, 1'b1, 1'b0, 2'd1, 3'd1},
    '{2'b00, 1'b1, 1'b0, 1'b1, 16'h01F1, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hE005, 1'b1, 1'b0, 2'd3, 3'd5},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hE00C, 1'b1, 1'b1, 2'd3, 3'd4},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hE010, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b11, 1'b1, 1'b0, 1'b1, 16'hE005, 1'b0, 1'b0, 2'd0, 3'd0},
    '{2'b00, 1'b1, 1'b1, 1'b0, 16'hE00A, 1'b1, 1'b1, 2'd3, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        nat_p, nat_s, allow, io_en, sec_en, valid;
  logic [15:0] pcmd, pctl, scmd, sctl, bmbar, addr;
  logic        hit, chan, pirq, sirq, pact, sact;
  logic [1:0]  kind;
  logic [2:0]  off;
  logic [15:0] pbase, pport, sbase, sport, bbase;
  logic        s_hit, s_chan, s_pirq, s_sirq, s_pact, s_sact;
  logic [1:0]  s_kind;
  logic [2:0]  s_off;
  logic [15:0] s_pbase, s_pport, s_sbase, s_sport, s_bbase;

  ide_io_decoder i_ide_io_decoder (
    .cfg_pri_native_req(nat_p), .cfg_sec_native_req(nat_s), .cfg_native_allow(allow),
    .cfg_io_en(io_en), .cfg_sec_enable(sec_en),
    .cfg_pri_cmd_bar(pcmd), .cfg_pri_ctl_bar(pctl), .cfg_sec_cmd_bar(scmd),
    .cfg_sec_ctl_bar(sctl), .cfg_bm_bar(bmbar), .io_valid(valid), .io_addr(addr),
    .dec_hit(hit), .dec_chan(chan), .dec_kind(kind), .dec_offset(off),
    .pri_cmd_base(pbase), .pri_ctl_port(pport), .sec_cmd_base(sbase), .sec_ctl_port(sport),
    .bm_base(bbase), .pri_irq_pin(pirq), .sec_irq_pin(sirq), .pri_active(pact), .sec_active(sact)
  );

  ide_io_decoder #(.SINGLE_CHANNEL(1'b1)) i_ide_io_decoder_single (
    .cfg_pri_native_req(nat_p), .cfg_sec_native_req(nat_s), .cfg_native_allow(allow),
    .cfg_io_en(io_en), .cfg_sec_enable(sec_en),
    .cfg_pri_cmd_bar(pcmd), .cfg_pri_ctl_bar(pctl), .cfg_sec_cmd_bar(scmd),
    .cfg_sec_ctl_bar(sctl), .cfg_bm_bar(bmbar), .io_valid(valid), .io_addr(addr),
    .dec_hit(s_hit), .dec_chan(s_chan), .dec_kind(s_kind), .dec_offset(s_off),
    .pri_cmd_base(s_pbase), .pri_ctl_port(s_pport), .sec_cmd_base(s_sbase), .sec_ctl_port(s_sport),
    .bm_base(s_bbase), .pri_irq_pin(s_pirq), .sec_irq_pin(s_sirq), .pri_active(s_pact), .sec_active(s_sact)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    if (i <= 5)  return "R2";
    if (i <= 9)  return "R3";
    if (i <= 12) return "R1";
    if (i <= 15) return "R5";
    return "R6";
  endfunction

  task automatic setup(input logic [1:0] nat, input logic al, input logic io,
                       input logic se, input logic [15:0] a);
    @(negedge clk);
    {nat_s, nat_p} = nat;
    allow  = al;
    io_en  = io;
    sec_en = se;
    valid  = 1'b1;
    addr   = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {nat_p, nat_s, allow, io_en, sec_en, valid} = '0;
    pcmd = 16'hD001; pctl = 16'hD407; scmd = 16'hD80F; sctl = 16'hDC05;
    bmbar = 16'hE00D; addr = 16'h01F0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle configuration: nothing decodes, compatibility ports reported (R9, R3)
    check("R9 idle hit", {15'd0, hit}, 16'd0);
    check("R3 idle primary base", pbase, 16'h01F0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setup(TBL[i].nat, TBL[i].allow, TBL[i].io, TBL[i].sec, TBL[i].addr);
      check({req_of(i), " hit"}, {15'd0, hit}, {15'd0, TBL[i].hit});
      check({req_of(i), " R10 kind"}, {14'd0, kind}, {14'd0, TBL[i].kind});
      if (TBL[i].hit) begin
        check({req_of(i), " R10 chan"}, {15'd0, chan}, {15'd0, TBL[i].chan});
        check({req_of(i), " R10 offset"}, {13'd0, off}, {13'd0, TBL[i].off});
      end
    end

    // Native window bases (R2, R6)
    setup(2'b11, 1'b1, 1'b1, 1'b1, 16'h0000);
    check("R2 pri cmd base", pbase, 16'hD000);
    check("R2 pri ctl port", pport, 16'hD406);
    check("R2 sec cmd base", sbase, 16'hD808);
    check("R2 sec ctl port", sport, 16'hDC06);
    check("R6 bm base", bbase, 16'hE000);

    // Interrupt routing ignores native permission (R4)
    setup(2'b11, 1'b0, 1'b1, 1'b1, 16'h0000);
    check("R4 pri pin", {15'd0, pirq}, 16'd1);
    check("R4 sec pin", {15'd0, sirq}, 16'd1);
    check("R1 legacy sec base", sbase, 16'h0170);
    setup(2'b10, 1'b1, 1'b1, 1'b1, 16'h0000);
    check("R4 pri legacy", {15'd0, pirq}, 16'd0);
    check("R4 sec pin native", {15'd0, sirq}, 16'd1);

    // Enables (R5)
    setup(2'b00, 1'b1, 1'b1, 1'b0, 16'h0000);
    check("R5 sec inactive", {15'd0, sact}, 16'd0);
    check("R5 pri active", {15'd0, pact}, 16'd1);

    // Overlap priority (R8)
    scmd = 16'hD000;
    setup(2'b11, 1'b1, 1'b1, 1'b1, 16'hD002);
    check("R8 pri over sec chan", {15'd0, chan}, 16'd0);
    check("R8 pri over sec kind", {14'd0, kind}, 16'd1);
    scmd = 16'hD80F;
    bmbar = 16'h01F0;
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'h01F3);
    check("R8 cmd over bm kind", {14'd0, kind}, 16'd1);
    bmbar = 16'hE00D;

    // Valid low (R9)
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'h01F0);
    valid = 1'b0;
    #1;
    check("R9 valid low hit", {15'd0, hit}, 16'd0);
    check("R9 valid low kind", {14'd0, kind}, 16'd0);

    // Single-channel build (R7)
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'h0170);
    check("R7 single sec cmd", {15'd0, s_hit}, 16'd0);
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'h0376);
    check("R7 single sec ctl", {15'd0, s_hit}, 16'd0);
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'hE00A);
    check("R7 single sec bm", {15'd0, s_hit}, 16'd0);
    check("R7 single sec active", {15'd0, s_sact}, 16'd0);
    setup(2'b00, 1'b1, 1'b1, 1'b1, 16'h01F4);
    check("R7 single pri still decodes", {14'd0, s_kind}, 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule